// File: doc/BRIEF.md
# Operand Bypass and Load Interlock Controller

This block is the hazard control for a five-stage in-order integer pipeline (fetch, decode, execute, memory, writeback). Each cycle it receives a summary of the instruction sitting in decode: its source register numbers, which sources feed the ALU, whether it is a load or a store, and its destination. It keeps its own registered copy of that summary as the instruction moves through execute, memory and writeback. From that copy it drives the operand multiplexer selects for execute, the select for store write data in execute, and a late select that feeds loaded data into a store's write data while the store is in the memory stage.

When a load in execute is followed directly by an instruction that reads the loaded register as an ALU operand, the block raises a hold. The hold freezes the program counter and the fetch/decode register. For that cycle it also loads an empty slot into its execute copy, so a bubble follows the load. One cycle later the dependent instruction enters execute and takes the loaded value from the memory/writeback register. The register file, ALU and memories sit outside the block and are seen only through these selects.

Top module: `fwd_interlock_unit`

## Requirements
- R1: While reset is high and in the first cycle after it, hold_front is 0, ex_valid is 0, all three execute selects are 2'b00 (register file) and mem_sd_from_wb is 0.
- R2: If the instruction one ahead, now in the memory stage, is not a load, writes register r and r is a used source of the instruction in execute, that source's select is 2'b10 (memory-stage ALU result).
- R3: If the instruction two ahead, now in writeback, writes register r (ALU result or loaded data), r is a used source and the rule in R2 does not apply, that source's select is 2'b01 (writeback value).
- R4: When both the memory-stage and writeback-stage producers write the same used source register, the select is 2'b10: the younger result wins.
- R5: Register 0 never causes a forward or a hold, and a producer whose write enable is 0 never matches.
- R6: A producer three instructions ahead of the consumer gives select 2'b00, because the register file writes before it reads within a cycle.
- R7: A load in execute whose destination (not register 0) is an ALU source of a valid instruction in decode raises hold_front for exactly one cycle. The next cycle ex_valid is 0 (bubble). In the cycle after that, the dependent instruction is in execute with select 2'b01.
- R8: Store write data uses its own select in execute, following the rules of R2 to R4. A store whose data register is loaded by the instruction just before it causes no hold. Its execute store select is then 2'b00, and in the following cycle mem_sd_from_wb is 1.
- R9: A source not flagged as used (use flag 0, or not a store for the data path) gets select 2'b00 and never causes a hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dec_valid | input | 1 | Decode holds a real instruction |
| dec_rs1 | input | 5 | First source register number |
| dec_rs2 | input | 5 | Second source register number (also store data) |
| dec_use_rs1 | input | 1 | First source feeds ALU operand A |
| dec_use_rs2 | input | 1 | Second source feeds ALU operand B |
| dec_store | input | 1 | Instruction is a store; rs2 is its write data |
| dec_load | input | 1 | Instruction is a load |
| dec_wr_en | input | 1 | Instruction writes its destination register |
| dec_rd | input | 5 | Destination register number |
| hold_front | output | 1 | Freeze PC and fetch/decode register; bubble into execute |
| ex_valid | output | 1 | Execute holds a real instruction (0 means bubble) |
| ex_sel_a | output | 2 | Operand A select: 00 register file, 01 writeback, 10 memory stage |
| ex_sel_b | output | 2 | Operand B select, same encoding |
| ex_sel_sd | output | 2 | Store data select in execute, same encoding |
| mem_sd_from_wb | output | 1 | Store in memory stage takes its write data from the writeback-stage load |

## Verification
The assertions assume that the fetch/decode register really is frozen while hold_front is high, so the decode summary is still present the next cycle. They also assume that a load always has its write enable set, that a store never does, and that no instruction is both. The bench models the frozen register itself by re-presenting the same decode summary until the hold drops. Its random generator builds every instruction so that these flags stay consistent. Register numbers are drawn from a small range so that matches, double matches, register 0 and disabled writers all occur often.

// File: rtl/fwd_pkg.sv
package fwd_pkg;

    parameter int unsigned RIDX_W = 5;
    localparam int unsigned NUM_SEL = 3;

    typedef logic [RIDX_W-1:0] ridx_t;

    typedef enum logic [1:0] {
        SRC_RF  = 2'b00,
        SRC_WB  = 2'b01,
        SRC_MEM = 2'b10
    } src_sel_e;

    // Decode / execute summary
    typedef struct packed {
        logic  valid;
        logic  wr_en;
        logic  is_load;
        logic  is_store;
        ridx_t rd;
        ridx_t rs1;
        ridx_t rs2;
        logic  use_rs1;
        logic  use_rs2;
    } slot_t;

    // Memory-stage summary
    typedef struct packed {
        logic  valid;
        logic  wr_en;
        logic  is_load;
        logic  is_store;
        ridx_t rd;
        ridx_t rs2;
    } late_t;

    // Writeback-stage summary
    typedef struct packed {
        logic  valid;
        logic  wr_en;
        logic  is_load;
        ridx_t rd;
    } wb_t;

    function automatic late_t to_late(slot_t s);
        late_t l;
        l.valid    = s.valid;
        l.wr_en    = s.wr_en;
        l.is_load  = s.is_load;
        l.is_store = s.is_store;
        l.rd       = s.rd;
        l.rs2      = s.rs2;
        return l;
    endfunction

    function automatic wb_t to_wb(late_t l);
        wb_t w;
        w.valid   = l.valid;
        w.wr_en   = l.wr_en;
        w.is_load = l.is_load;
        w.rd      = l.rd;
        return w;
    endfunction

    // A live producer that writes a nonzero register equal to r
    function automatic logic produces(logic v, logic we, ridx_t rd, ridx_t r);
        return v && we && (rd != '0) && (rd == r);
    endfunction

endpackage

// File: rtl/hazard_pipe.sv
module hazard_pipe
    import fwd_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  slot_t dec_slot,
    input  logic  bubble,
    output slot_t idex,
    output late_t exmem,
    output wb_t   memwb
);

    always_ff @(posedge clk) begin
        if (rst) begin
            idex  <= '0;
            exmem <= '0;
            memwb <= '0;
        end else begin
            idex  <= bubble ? slot_t'('0) : dec_slot;
            exmem <= to_late(idex);
            memwb <= to_wb(exmem);
        end
    end

    // R7: a hold leaves an empty execute slot behind it
    a_r7_bubble_inserted: assert property (@(posedge clk) disable iff (rst)
        bubble |=> !idex.valid);

    // R7: older work keeps moving during a hold
    a_r7_older_advance: assert property (@(posedge clk) disable iff (rst)
        (bubble && idex.valid) |=> exmem.valid);

endmodule

// File: rtl/loaduse_detect.sv
module loaduse_detect
    import fwd_pkg::*;
(
    input  slot_t dec_slot,
    input  slot_t idex,
    output logic  hold
);

    logic ld_in_ex;
    logic hit_a;
    logic hit_b;

    always_comb begin
        ld_in_ex = idex.valid && idex.is_load && idex.wr_en && (idex.rd != '0);
        hit_a    = dec_slot.use_rs1 && (dec_slot.rs1 == idex.rd);
        hit_b    = dec_slot.use_rs2 && (dec_slot.rs2 == idex.rd);
        hold     = dec_slot.valid && ld_in_ex && (hit_a || hit_b);
    end

endmodule

// File: rtl/fwd_select.sv
module fwd_select
    import fwd_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     need,
    input  ridx_t    rs,
    input  logic     mem_valid,
    input  logic     mem_wr_en,
    input  logic     mem_load,
    input  ridx_t    mem_rd,
    input  logic     wb_valid,
    input  logic     wb_wr_en,
    input  ridx_t    wb_rd,
    output src_sel_e sel
);

    logic mem_hit;
    logic wb_hit;

    always_comb begin
        mem_hit = need && produces(mem_valid, mem_wr_en, mem_rd, rs);
        wb_hit  = need && produces(wb_valid, wb_wr_en, wb_rd, rs);
        if (mem_hit)
            sel = mem_load ? SRC_RF : SRC_MEM;
        else if (wb_hit)
            sel = SRC_WB;
        else
            sel = SRC_RF;
    end

    // R5: register 0 is never bypassed
    a_r5_zero_never: assert property (@(posedge clk) disable iff (rst)
        (rs == '0) |-> (sel == SRC_RF));

    // R9: an unused source stays on the register file
    a_r9_unused_rf: assert property (@(posedge clk) disable iff (rst)
        !need |-> (sel == SRC_RF));

    // R2: a load address is never taken as an operand
    a_r2_no_load_bypass: assert property (@(posedge clk) disable iff (rst)
        (sel == SRC_MEM) |-> (mem_valid && !mem_load));

    // R3: writeback select only with a live writer there
    a_r3_wb_writer: assert property (@(posedge clk) disable iff (rst)
        (sel == SRC_WB) |-> (wb_valid && wb_wr_en));

endmodule

// File: rtl/fwd_interlock_unit.sv
module fwd_interlock_unit
    import fwd_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                dec_valid,
    input  logic [RIDX_W-1:0]   dec_rs1,
    input  logic [RIDX_W-1:0]   dec_rs2,
    input  logic                dec_use_rs1,
    input  logic                dec_use_rs2,
    input  logic                dec_store,
    input  logic                dec_load,
    input  logic                dec_wr_en,
    input  logic [RIDX_W-1:0]   dec_rd,
    output logic                hold_front,
    output logic                ex_valid,
    output logic [1:0]          ex_sel_a,
    output logic [1:0]          ex_sel_b,
    output logic [1:0]          ex_sel_sd,
    output logic                mem_sd_from_wb
);

    slot_t    dec_slot;
    slot_t    idex;
    late_t    exmem;
    wb_t      memwb;
    logic     hold;
    logic     [NUM_SEL-1:0] need;
    ridx_t    src_idx [NUM_SEL];
    src_sel_e sel     [NUM_SEL];

    always_comb begin
        dec_slot.valid    = dec_valid;
        dec_slot.wr_en    = dec_wr_en;
        dec_slot.is_load  = dec_load;
        dec_slot.is_store = dec_store;
        dec_slot.rd       = dec_rd;
        dec_slot.rs1      = dec_rs1;
        dec_slot.rs2      = dec_rs2;
        dec_slot.use_rs1  = dec_use_rs1;
        dec_slot.use_rs2  = dec_use_rs2;
    end

    loaduse_detect u_detect (
        .dec_slot (dec_slot),
        .idex     (idex),
        .hold     (hold)
    );

    hazard_pipe u_pipe (
        .clk      (clk),
        .rst      (rst),
        .dec_slot (dec_slot),
        .bubble   (hold),
        .idex     (idex),
        .exmem    (exmem),
        .memwb    (memwb)
    );

    // Port 0: operand A, port 1: operand B, port 2: store data
    always_comb begin
        need[0]    = idex.valid && idex.use_rs1;
        need[1]    = idex.valid && idex.use_rs2;
        need[2]    = idex.valid && idex.is_store;
        src_idx[0] = idex.rs1;
        src_idx[1] = idex.rs2;
        src_idx[2] = idex.rs2;
    end

    for (genvar g = 0; g < NUM_SEL; g++) begin : g_sel
        fwd_select u_sel (
            .clk       (clk),
            .rst       (rst),
            .need      (need[g]),
            .rs        (src_idx[g]),
            .mem_valid (exmem.valid),
            .mem_wr_en (exmem.wr_en),
            .mem_load  (exmem.is_load),
            .mem_rd    (exmem.rd),
            .wb_valid  (memwb.valid),
            .wb_wr_en  (memwb.wr_en),
            .wb_rd     (memwb.rd),
            .sel       (sel[g])
        );
    end

    always_comb begin
        hold_front     = hold;
        ex_valid       = idex.valid;
        ex_sel_a       = sel[0];
        ex_sel_b       = sel[1];
        ex_sel_sd      = sel[2];
        mem_sd_from_wb = exmem.valid && exmem.is_store && memwb.is_load
                         && produces(memwb.valid, memwb.wr_en, memwb.rd, exmem.rs2);
    end

    // R7: the hold lasts exactly one cycle
    a_r7_single_hold: assert property (@(posedge clk) disable iff (rst)
        hold_front |=> !hold_front);

    // R7: after a hold and its bubble, the consumer reads the writeback value
    a_r7_then_forward: assert property (@(posedge clk) disable iff (rst)
        $past(hold_front) && !ex_valid |=> (ex_sel_a == 2'b01 || ex_sel_b == 2'b01));

    // R8: a late store-data forward follows an execute cycle that did not bypass from memory
    a_r8_late_store: assert property (@(posedge clk) disable iff (rst)
        mem_sd_from_wb |-> ($past(ex_sel_sd) == 2'b00));

    // R1: nothing is live in execute right after reset
    a_r1_reset_empty: assert property (@(posedge clk)
        rst |=> !ex_valid);

endmodule

// File: tb/tb_fwd_interlock_unit.sv
module tb_fwd_interlock_unit;

    typedef struct {
        bit v, we, ld, st, u1, u2;
        int rd, rs1, rs2;
    } ins_t;

    logic       clk = 1'b0;
    logic       rst;
    logic       dec_valid, dec_use_rs1, dec_use_rs2, dec_store, dec_load, dec_wr_en;
    logic [4:0] dec_rs1, dec_rs2, dec_rd;
    logic       hold_front, ex_valid, mem_sd_from_wb;
    logic [1:0] ex_sel_a, ex_sel_b, ex_sel_sd;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #2.5 clk = ~clk;

    fwd_interlock_unit dut (
        .clk(clk), .rst(rst),
        .dec_valid(dec_valid), .dec_rs1(dec_rs1), .dec_rs2(dec_rs2),
        .dec_use_rs1(dec_use_rs1), .dec_use_rs2(dec_use_rs2),
        .dec_store(dec_store), .dec_load(dec_load), .dec_wr_en(dec_wr_en),
        .dec_rd(dec_rd),
        .hold_front(hold_front), .ex_valid(ex_valid),
        .ex_sel_a(ex_sel_a), .ex_sel_b(ex_sel_b), .ex_sel_sd(ex_sel_sd),
        .mem_sd_from_wb(mem_sd_from_wb)
    );

    ins_t m_ex, m_mem, m_wb, m_gone, cur, empty;
    ins_t dir [19];
    int   pos = 0;

    function automatic ins_t mk(bit we, bit ld, bit st, int rd,
                                int rs1, bit u1, int rs2, bit u2);
        ins_t i;
        i.v = 1; i.we = we; i.ld = ld; i.st = st; i.rd = rd;
        i.rs1 = rs1; i.u1 = u1; i.rs2 = rs2; i.u2 = u2;
        return i;
    endfunction

    function automatic bit wrm(ins_t p, int r);
        return p.v && p.we && r != 0 && p.rd == r;
    endfunction

    function automatic int exp_sel(bit need, int rs);
        if (!need || rs == 0) return 0;
        if (wrm(m_mem, rs)) return m_mem.ld ? 0 : 2;
        if (wrm(m_wb, rs)) return 1;
        return 0;
    endfunction

    function automatic string sel_tag(bit need, int rs, int e);
        if (!need) return "R9";
        if (rs == 0) return "R5";
        if (e == 2 && wrm(m_wb, rs)) return "R4";
        if (e == 2) return "R2";
        if (e == 1) return "R3";
        if (wrm(m_mem, rs)) return "R8";
        if ((m_mem.v && !m_mem.we && m_mem.rd == rs) ||
            (m_wb.v && !m_wb.we && m_wb.rd == rs)) return "R5";
        if (wrm(m_gone, rs)) return "R6";
        return "R2";
    endfunction

    function automatic ins_t rnd_ins();
        ins_t i;
        int k;
        i.v   = ($urandom_range(0, 9) != 0);
        k     = $urandom_range(0, 5);
        i.ld  = (k == 0 || k == 1);
        i.st  = (k == 2);
        i.we  = i.ld ? 1'b1 : (i.st ? 1'b0 : ($urandom_range(0, 4) != 0));
        i.rd  = $urandom_range(0, 3);
        i.rs1 = $urandom_range(0, 3);
        i.rs2 = $urandom_range(0, 3);
        i.u1  = $urandom_range(0, 3) != 0;
        i.u2  = i.st ? 1'b0 : ($urandom_range(0, 1) != 0);
        return i;
    endfunction

    function automatic ins_t next_ins();
        if (pos < 19) begin
            pos++;
            return dir[pos-1];
        end
        return rnd_ins();
    endfunction

    task automatic chk(string tag, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic drive(ins_t i);
        dec_valid   = i.v;   dec_wr_en   = i.we;  dec_load  = i.ld;
        dec_store   = i.st;  dec_use_rs1 = i.u1;  dec_use_rs2 = i.u2;
        dec_rd      = 5'(i.rd);  dec_rs1 = 5'(i.rs1);  dec_rs2 = 5'(i.rs2);
    endtask

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        bit es, emsd;
        int ea, eb, esd;
        void'($urandom(32'd20240611));
        empty = '{v:0, we:0, ld:0, st:0, u1:0, u2:0, rd:0, rs1:0, rs2:0};
        // directed corner cases
        dir[0]  = mk(1,0,0, 1, 0,0, 0,0);   // writes r1
        dir[1]  = mk(1,0,0, 0, 1,1, 1,1);   // R2 distance one
        dir[2]  = mk(0,0,0, 0, 1,1, 0,0);   // R3 distance two
        dir[3]  = mk(0,0,0, 0, 1,1, 0,0);   // R6 distance three
        dir[4]  = mk(1,0,0, 2, 0,0, 0,0);
        dir[5]  = mk(1,0,0, 2, 0,0, 0,0);
        dir[6]  = mk(0,0,0, 0, 2,1, 0,0);   // R4 double match
        dir[7]  = mk(1,0,0, 0, 0,0, 0,0);   // writes r0
        dir[8]  = mk(0,0,0, 0, 0,1, 0,1);   // R5 zero register
        dir[9]  = mk(0,0,0, 3, 0,0, 0,0);   // rd=3, no write
        dir[10] = mk(0,0,0, 0, 3,1, 0,0);   // R5 disabled writer
        dir[11] = mk(1,1,0, 1, 0,0, 0,0);   // load r1
        dir[12] = mk(0,0,0, 0, 0,0, 1,1);   // R7 load-use
        dir[13] = mk(1,1,0, 2, 0,0, 0,0);   // load r2
        dir[14] = mk(0,0,1, 0, 0,1, 2,0);   // R8 store of loaded data
        dir[15] = mk(1,0,0, 3, 0,0, 0,0);
        dir[16] = mk(0,0,1, 0, 0,1, 3,0);   // R8 store data bypass
        dir[17] = mk(1,1,0, 1, 0,0, 0,0);   // load r1
        dir[18] = mk(0,0,0, 0, 1,0, 1,0);   // R9 unused sources

        rst = 1'b1;
        drive(empty);
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1", "hold_front", int'(hold_front), 0);
        chk("R1", "ex_valid", int'(ex_valid), 0);
        chk("R1", "ex_sel_a", int'(ex_sel_a), 0);
        chk("R1", "ex_sel_b", int'(ex_sel_b), 0);
        chk("R1", "ex_sel_sd", int'(ex_sel_sd), 0);
        chk("R1", "mem_sd_from_wb", int'(mem_sd_from_wb), 0);
        rst = 1'b0;
        m_ex = empty; m_mem = empty; m_wb = empty; m_gone = empty;
        cur = next_ins();

        for (int c = 0; c < 3000; c++) begin
            @(negedge clk);
            drive(cur);
            #1;
            es = cur.v && m_ex.v && m_ex.ld && m_ex.we && m_ex.rd != 0 &&
                 ((cur.u1 && cur.rs1 == m_ex.rd) || (cur.u2 && cur.rs2 == m_ex.rd));
            ea   = exp_sel(m_ex.v && m_ex.u1, m_ex.rs1);
            eb   = exp_sel(m_ex.v && m_ex.u2, m_ex.rs2);
            esd  = exp_sel(m_ex.v && m_ex.st, m_ex.rs2);
            emsd = m_mem.v && m_mem.st && m_wb.ld && wrm(m_wb, m_mem.rs2);
            chk("R7", "hold_front", int'(hold_front), int'(es));
            chk("R7", "ex_valid", int'(ex_valid), int'(m_ex.v));
            chk(sel_tag(m_ex.v && m_ex.u1, m_ex.rs1, ea), "ex_sel_a", int'(ex_sel_a), ea);
            chk(sel_tag(m_ex.v && m_ex.u2, m_ex.rs2, eb), "ex_sel_b", int'(ex_sel_b), eb);
            chk(sel_tag(m_ex.v && m_ex.st, m_ex.rs2, esd), "ex_sel_sd", int'(ex_sel_sd), esd);
            chk("R8", "mem_sd_from_wb", int'(mem_sd_from_wb), int'(emsd));
            m_gone = m_wb;
            m_wb   = m_mem;
            m_mem  = m_ex;
            m_ex   = es ? empty : cur;
            if (!es) cur = next_ins();
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule